// File: doc/BRIEF.md
# Fully Associative Branch Target Buffer with Return Stack

This block predicts the next fetch address for a fetch unit. Each cycle the fetch stage presents an address. If a valid entry holds that address, the block returns the stored target in the same cycle. A simple policy applies: a hit means the branch is predicted taken. Resolved branches come back on an update port, and those that were taken are written into the buffer. Any entry may hold any branch. When the branch is already present, its entry is overwritten in place. Otherwise the lowest free entry is used, and when no entry is free a round-robin victim pointer chooses one.

A 6-bit control register holds the global switch, a write-one flush and two direction filters. The register is all zero after reset, so the buffer starts switched off. Software flushes the buffer and then sets the enable bit. A direction filter decides whether backward branches, forward branches, both or neither may be allocated or predicted. A branch is backward when its target is numerically lower than its own address. A separate return stack records return addresses pushed on calls. It supplies the target when the fetch stage marks a lookup as a return.

Top module: `fa_btb`

## Requirements
- R1: After reset `ctrl_rdata` reads 0 and no lookup produces a prediction.
- R2: With the enable bit (control bit 0) set, a lookup (`lk_valid`, `lk_is_ret`=0) whose address matches any valid entry raises `pred_hit` in the same cycle, with that entry's target on `pred_target` and `pred_from_ras`=0.
- R3: A control write with bit 1 set clears every entry and the return stack at the next edge. In the write cycle itself no lookup hits. Bit 1 always reads back as 0.
- R4: While the enable bit is clear, no lookup predicts and no update allocates. The enable bit changes one cycle after the write.
- R5: Control bits [3:2] filter allocation. 00 allows both directions, 01 allows backward only, 10 allows forward only and 11 allows none. A filtered taken update leaves the buffer unchanged.
- R6: Control bits [5:4] filter prediction with the same encoding, judged on the stored target against the lookup address.
- R7: A branch is backward exactly when its target is lower than its address, compared as unsigned values. A target equal to the address counts as forward.
- R8: A taken update for an address already present replaces that entry's target, and no duplicate entry is made.
- R9: A new branch takes the lowest-numbered invalid entry. When all entries are valid, it takes the entry at a round-robin pointer. The pointer starts at 0, advances by one (wrapping) on each such replacement, and returns to 0 on a flush.
- R10: An update with `upd_taken`=0 has no effect on the buffer.
- R11: `call_push` pushes `call_ret_addr`. A return lookup with the stack not empty predicts the top address, with `pred_from_ras`=1. `ret_pop` removes the top. A push and a pop in the same cycle replace the top.
- R12: The return stack holds RAS_DEPTH (4) addresses. A push beyond that overwrites the oldest. A return lookup or a pop on an empty stack yields no prediction and no change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ctrl_we | input | 1 | Control register write strobe |
| ctrl_wdata | input | 6 | Control write data: [0] enable, [1] flush, [3:2] allocation filter, [5:4] prediction filter |
| ctrl_rdata | output | 6 | Control register read value (bit 1 always 0) |
| lk_valid | input | 1 | Lookup request |
| lk_pc | input | ADDR_W | Fetch address to look up |
| lk_is_ret | input | 1 | Lookup is a return; predict from the return stack |
| pred_hit | output | 1 | Prediction valid (taken) |
| pred_target | output | ADDR_W | Predicted target, 0 when no hit |
| pred_from_ras | output | 1 | Prediction came from the return stack |
| upd_valid | input | 1 | Resolved branch report |
| upd_pc | input | ADDR_W | Address of the resolved branch |
| upd_target | input | ADDR_W | Resolved target |
| upd_taken | input | 1 | Branch was taken |
| call_push | input | 1 | Push a return address |
| call_ret_addr | input | ADDR_W | Return address to push |
| ret_pop | input | 1 | Pop the return stack |

## Verification
The checker asserts the following on every cycle:
- No prediction is made while the block is disabled or in a flush-write cycle.
- A flush leaves no valid entry and an empty stack.
- At most one entry ever matches an address.
- The stack count stays within its depth.
- Overwriting an existing address keeps the number of valid entries unchanged.

Some properties need a known sequence of writes, and only the bench can show them. These are the direction filters, which entry a replacement evicts, LIFO ordering after a wrap, and the exact predicted targets. The bench compares these against its own model, under both directed sequences and seeded random traffic.

// File: rtl/fa_btb_pkg.sv
package fa_btb_pkg;

  // Direction filter encoding shared by the allocation and prediction fields
  typedef enum logic [1:0] {
    DIR_BOTH = 2'b00,
    DIR_BWD  = 2'b01,
    DIR_FWD  = 2'b10,
    DIR_NONE = 2'b11
  } dir_filt_e;

  typedef struct packed {
    dir_filt_e pred_f;
    dir_filt_e alloc_f;
    logic      en;
  } ctrl_t;

  localparam int CTRL_W    = 6;
  localparam int BIT_EN    = 0;
  localparam int BIT_FLUSH = 1;

  // Does the filter let a branch of the given direction through?
  function automatic logic dir_allowed(input dir_filt_e f, input logic bwd);
    case (f)
      DIR_BOTH: dir_allowed = 1'b1;
      DIR_BWD:  dir_allowed = bwd;
      DIR_FWD:  dir_allowed = ~bwd;
      default:  dir_allowed = 1'b0;
    endcase
  endfunction

endpackage

// File: rtl/fa_btb_ctrl.sv
module fa_btb_ctrl
  import fa_btb_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [CTRL_W-1:0] wdata,
  output ctrl_t             ctrl,
  output logic              flush_req,
  output logic [CTRL_W-1:0] rdata
);

  ctrl_t ctrl_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctrl_q <= '0;
    end else if (we) begin
      ctrl_q.en      <= wdata[BIT_EN];
      ctrl_q.alloc_f <= dir_filt_e'(wdata[3:2]);
      ctrl_q.pred_f  <= dir_filt_e'(wdata[5:4]);
    end
  end

  assign flush_req = we & wdata[BIT_FLUSH];
  assign ctrl      = ctrl_q;
  assign rdata     = {ctrl_q.pred_f, ctrl_q.alloc_f, 1'b0, ctrl_q.en};

endmodule

// File: rtl/fa_btb_cam.sv
module fa_btb_cam #(
  parameter int ADDR_W  = 32,
  parameter int ENTRIES = 8,
  localparam int IW = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               flush,
  input  logic               wr_en,
  input  logic [IW-1:0]      wr_idx,
  input  logic [ADDR_W-1:0]  wr_pc,
  input  logic [ADDR_W-1:0]  wr_tgt,
  input  logic [ADDR_W-1:0]  lk_pc,
  output logic [ENTRIES-1:0] hit_vec,
  output logic [ADDR_W-1:0]  hit_tgt,
  output logic [ENTRIES-1:0] upd_match_vec,
  output logic [ENTRIES-1:0] valid_vec
);

  logic [ADDR_W-1:0] tag_q [ENTRIES];
  logic [ADDR_W-1:0] tgt_q [ENTRIES];
  logic [ENTRIES-1:0] vld_q;

  for (genvar g = 0; g < ENTRIES; g++) begin : g_ent
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        vld_q[g] <= 1'b0;
        tag_q[g] <= '0;
        tgt_q[g] <= '0;
      end else if (flush) begin
        vld_q[g] <= 1'b0;
      end else if (wr_en && wr_idx == IW'(g)) begin
        vld_q[g] <= 1'b1;
        tag_q[g] <= wr_pc;
        tgt_q[g] <= wr_tgt;
      end
    end
    assign hit_vec[g]       = vld_q[g] && (tag_q[g] == lk_pc);
    assign upd_match_vec[g] = vld_q[g] && (tag_q[g] == wr_pc);
  end

  // One-hot select of the matching target (entries never duplicate)
  always_comb begin
    hit_tgt = '0;
    for (int i = 0; i < ENTRIES; i++) begin
      hit_tgt = hit_tgt | (tgt_q[i] & {ADDR_W{hit_vec[i]}});
    end
  end

  assign valid_vec = vld_q;

endmodule

// File: rtl/fa_btb_victim.sv
module fa_btb_victim #(
  parameter int ENTRIES = 8,
  localparam int IW = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               flush,
  input  logic               fire,
  input  logic [ENTRIES-1:0] valid_vec,
  input  logic [ENTRIES-1:0] match_vec,
  output logic [IW-1:0]      idx,
  output logic               evict
);

  logic [IW-1:0] rr_q;
  logic [IW-1:0] match_idx;
  logic [IW-1:0] free_idx;
  logic          any_free;

  always_comb begin
    match_idx = '0;
    for (int i = 0; i < ENTRIES; i++) begin
      if (match_vec[i]) match_idx = match_idx | IW'(i);
    end
  end

  always_comb begin
    free_idx = '0;
    any_free = 1'b0;
    for (int i = ENTRIES - 1; i >= 0; i--) begin
      if (!valid_vec[i]) begin
        free_idx = IW'(i);
        any_free = 1'b1;
      end
    end
  end

  assign evict = ~(|match_vec) & ~any_free;

  always_comb begin
    if (|match_vec)    idx = match_idx;
    else if (any_free) idx = free_idx;
    else               idx = rr_q;
  end

  always_ff @(posedge clk) begin
    if (!rst_n || flush) begin
      rr_q <= '0;
    end else if (fire && evict) begin
      rr_q <= (rr_q == IW'(ENTRIES - 1)) ? '0 : rr_q + 1'b1;
    end
  end

endmodule

// File: rtl/fa_btb_ras.sv
module fa_btb_ras #(
  parameter int ADDR_W = 32,
  parameter int DEPTH  = 4,
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              flush,
  input  logic              push,
  input  logic [ADDR_W-1:0] push_addr,
  input  logic              pop,
  output logic [ADDR_W-1:0] top_addr,
  output logic              nonempty,
  output logic [CW-1:0]     count
);

  logic [ADDR_W-1:0] stk_q [DEPTH];
  logic [PW-1:0]     ptr_q;
  logic [CW-1:0]     cnt_q;
  logic              pop_eff;
  logic [PW-1:0]     ptr_up;
  logic [PW-1:0]     ptr_dn;

  assign pop_eff = pop && (cnt_q != '0);
  assign ptr_up  = (ptr_q == PW'(DEPTH - 1)) ? '0 : ptr_q + 1'b1;
  assign ptr_dn  = (ptr_q == '0) ? PW'(DEPTH - 1) : ptr_q - 1'b1;

  always_ff @(posedge clk) begin
    if (!rst_n || flush) begin
      ptr_q <= '0;
      cnt_q <= '0;
    end else if (push && pop_eff) begin
      stk_q[ptr_q] <= push_addr;
    end else if (push) begin
      stk_q[ptr_up] <= push_addr;
      ptr_q         <= ptr_up;
      if (cnt_q != CW'(DEPTH)) cnt_q <= cnt_q + 1'b1;
    end else if (pop_eff) begin
      ptr_q <= ptr_dn;
      cnt_q <= cnt_q - 1'b1;
    end
  end

  assign top_addr = stk_q[ptr_q];
  assign nonempty = (cnt_q != '0);
  assign count    = cnt_q;

endmodule

// File: rtl/fa_btb.sv
module fa_btb
  import fa_btb_pkg::*;
#(
  parameter int ADDR_W    = 32,
  parameter int ENTRIES   = 8,
  parameter int RAS_DEPTH = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ctrl_we,
  input  logic [5:0]        ctrl_wdata,
  output logic [5:0]        ctrl_rdata,
  input  logic              lk_valid,
  input  logic [ADDR_W-1:0] lk_pc,
  input  logic              lk_is_ret,
  output logic              pred_hit,
  output logic [ADDR_W-1:0] pred_target,
  output logic              pred_from_ras,
  input  logic              upd_valid,
  input  logic [ADDR_W-1:0] upd_pc,
  input  logic [ADDR_W-1:0] upd_target,
  input  logic              upd_taken,
  input  logic              call_push,
  input  logic [ADDR_W-1:0] call_ret_addr,
  input  logic              ret_pop
);

  localparam int IW = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;
  localparam int CW = $clog2(RAS_DEPTH + 1);

  // Named internal events, observed by the bound checker
  ctrl_t              ctrl;
  logic               flush_req;
  logic               en_q;
  logic [ENTRIES-1:0] hit_vec;
  logic [ENTRIES-1:0] upd_match_vec;
  logic [ENTRIES-1:0] valid_vec;
  logic [ADDR_W-1:0]  hit_tgt;
  logic [IW-1:0]      wr_idx;
  logic               evict;
  logic               alloc_fire;
  logic               btb_pred;
  logic               ras_pred;
  logic [ADDR_W-1:0]  ras_top;
  logic               ras_nonempty;
  logic [CW-1:0]      ras_count;

  function automatic logic backward(input logic [ADDR_W-1:0] pc,
                                    input logic [ADDR_W-1:0] tgt);
    return tgt < pc;
  endfunction

  fa_btb_ctrl u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .we        (ctrl_we),
    .wdata     (ctrl_wdata),
    .ctrl      (ctrl),
    .flush_req (flush_req),
    .rdata     (ctrl_rdata)
  );

  assign en_q = ctrl.en;

  assign alloc_fire = upd_valid && upd_taken && en_q && !flush_req &&
                      dir_allowed(ctrl.alloc_f, backward(upd_pc, upd_target));

  fa_btb_cam #(.ADDR_W(ADDR_W), .ENTRIES(ENTRIES)) u_cam (
    .clk           (clk),
    .rst_n         (rst_n),
    .flush         (flush_req),
    .wr_en         (alloc_fire),
    .wr_idx        (wr_idx),
    .wr_pc         (upd_pc),
    .wr_tgt        (upd_target),
    .lk_pc         (lk_pc),
    .hit_vec       (hit_vec),
    .hit_tgt       (hit_tgt),
    .upd_match_vec (upd_match_vec),
    .valid_vec     (valid_vec)
  );

  fa_btb_victim #(.ENTRIES(ENTRIES)) u_victim (
    .clk       (clk),
    .rst_n     (rst_n),
    .flush     (flush_req),
    .fire      (alloc_fire),
    .valid_vec (valid_vec),
    .match_vec (upd_match_vec),
    .idx       (wr_idx),
    .evict     (evict)
  );

  fa_btb_ras #(.ADDR_W(ADDR_W), .DEPTH(RAS_DEPTH)) u_ras (
    .clk       (clk),
    .rst_n     (rst_n),
    .flush     (flush_req),
    .push      (call_push),
    .push_addr (call_ret_addr),
    .pop       (ret_pop),
    .top_addr  (ras_top),
    .nonempty  (ras_nonempty),
    .count     (ras_count)
  );

  assign btb_pred = lk_valid && en_q && !flush_req && !lk_is_ret && (|hit_vec) &&
                    dir_allowed(ctrl.pred_f, backward(lk_pc, hit_tgt));
  assign ras_pred = lk_valid && en_q && !flush_req && lk_is_ret && ras_nonempty;

  assign pred_hit      = btb_pred | ras_pred;
  assign pred_from_ras = ras_pred;
  assign pred_target   = ras_pred ? ras_top : (btb_pred ? hit_tgt : '0);

endmodule

// File: rtl/fa_btb_chk.sv
module fa_btb_chk #(
  parameter int ENTRIES   = 8,
  parameter int RAS_DEPTH = 4,
  localparam int CW = $clog2(RAS_DEPTH + 1)
) (
  input logic               clk,
  input logic               rst_n,
  input logic [5:0]         ctrl_rdata,
  input logic               pred_hit,
  input logic               en_q,
  input logic               flush_req,
  input logic               alloc_fire,
  input logic [ENTRIES-1:0] hit_vec,
  input logic [ENTRIES-1:0] upd_match_vec,
  input logic [ENTRIES-1:0] valid_vec,
  input logic [CW-1:0]      ras_count
);

  p_dis_nopred_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !en_q |-> !pred_hit);

  p_flush_miss_r3: assert property (@(posedge clk) disable iff (!rst_n)
    flush_req |-> !pred_hit);

  p_flush_clear_r3: assert property (@(posedge clk) disable iff (!rst_n)
    flush_req |=> (valid_vec == '0) && (ras_count == '0));

  p_flush_rd0_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_rdata[1] == 1'b0);

  p_single_hit_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(hit_vec) && $onehot0(upd_match_vec));

  p_inplace_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (alloc_fire && (|upd_match_vec)) |=>
      ($countones(valid_vec) == $countones($past(valid_vec))));

  p_alloc_lands_r2: assert property (@(posedge clk) disable iff (!rst_n)
    alloc_fire |=> (|valid_vec));

  p_ras_cap_r12: assert property (@(posedge clk) disable iff (!rst_n)
    ras_count <= CW'(RAS_DEPTH));

endmodule

bind fa_btb fa_btb_chk #(.ENTRIES(ENTRIES), .RAS_DEPTH(RAS_DEPTH)) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .ctrl_rdata    (ctrl_rdata),
  .pred_hit      (pred_hit),
  .en_q          (en_q),
  .flush_req     (flush_req),
  .alloc_fire    (alloc_fire),
  .hit_vec       (hit_vec),
  .upd_match_vec (upd_match_vec),
  .valid_vec     (valid_vec),
  .ras_count     (ras_count)
);

// File: tb/fa_btb_bench.sv
`timescale 1ns/1ps
module fa_btb_bench;

  localparam int N = 8;
  localparam int D = 4;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ctrl_we = 1'b0;
  logic [5:0]  ctrl_wdata = '0;
  logic [5:0]  ctrl_rdata;
  logic        lk_valid = 1'b0;
  logic [31:0] lk_pc = '0;
  logic        lk_is_ret = 1'b0;
  logic        pred_hit;
  logic [31:0] pred_target;
  logic        pred_from_ras;
  logic        upd_valid = 1'b0;
  logic [31:0] upd_pc = '0;
  logic [31:0] upd_target = '0;
  logic        upd_taken = 1'b0;
  logic        call_push = 1'b0;
  logic [31:0] call_ret_addr = '0;
  logic        ret_pop = 1'b0;

  always #4 clk = ~clk;

  fa_btb u_fa_btb (.*);

  int vectors = 0;
  int miscompares = 0;
  bit done = 1'b0;

  // Reference model, written from the requirements
  logic [31:0] m_pc [N];
  logic [31:0] m_tg [N];
  bit          m_v  [N];
  int          m_rr;
  logic [31:0] m_ras [D];
  int          m_rp, m_rc;
  logic [5:0]  m_ctrl;

  function automatic bit b_pass(input bit [1:0] f, input bit back);
    return (f == 2'b00) || (f == 2'b01 && back) || (f == 2'b10 && !back);
  endfunction

  task automatic chk(input string tag, input string what, input logic [31:0] got,
                     input logic [31:0] exp);
    vectors++;
    if (got !== exp) begin
      miscompares++;
      $display("FAIL %s %s got %h exp %h", tag, what, got, exp);
    end
  endtask

  task automatic model_reset();
    for (int j = 0; j < N; j++) m_v[j] = 1'b0;
    m_rr = 0; m_rp = 0; m_rc = 0;
  endtask

  task automatic step(input bit cw, input bit [5:0] cd, input bit lv, input logic [31:0] lpc,
                      input bit lret, input bit uv, input logic [31:0] upc,
                      input logic [31:0] utg, input bit utk, input bit psh,
                      input logic [31:0] pa, input bit pp, input string tag);
    bit fl, e_hit, e_ras, mfound, ffound;
    logic [31:0] e_tgt;
    int slot;
    @(negedge clk);
    ctrl_we = cw; ctrl_wdata = cd; lk_valid = lv; lk_pc = lpc; lk_is_ret = lret;
    upd_valid = uv; upd_pc = upc; upd_target = utg; upd_taken = utk;
    call_push = psh; call_ret_addr = pa; ret_pop = pp;
    #1;
    fl = cw && cd[1];
    e_hit = 1'b0; e_ras = 1'b0; e_tgt = '0;
    if (lv && m_ctrl[0] && !fl) begin
      if (lret) begin
        if (m_rc > 0) begin e_hit = 1'b1; e_ras = 1'b1; e_tgt = m_ras[m_rp]; end
      end else begin
        for (int j = 0; j < N; j++)
          if (m_v[j] && m_pc[j] == lpc && b_pass(m_ctrl[5:4], m_tg[j] < lpc)) begin
            e_hit = 1'b1; e_tgt = m_tg[j];
          end
      end
    end
    chk(tag, "pred_hit", {31'd0, pred_hit}, {31'd0, e_hit});
    chk(tag, "pred_from_ras", {31'd0, pred_from_ras}, {31'd0, e_ras});
    chk(tag, "pred_target", pred_target, e_tgt);
    chk(tag, "ctrl_rdata", {26'd0, ctrl_rdata}, {26'd0, m_ctrl});
    @(posedge clk);
    if (fl) begin
      model_reset();
    end else begin
      if (uv && utk && m_ctrl[0] && b_pass(m_ctrl[3:2], utg < upc)) begin
        mfound = 1'b0; ffound = 1'b0; slot = 0;
        for (int j = 0; j < N; j++)
          if (m_v[j] && m_pc[j] == upc) begin mfound = 1'b1; slot = j; end
        if (!mfound)
          for (int j = N - 1; j >= 0; j--)
            if (!m_v[j]) begin ffound = 1'b1; slot = j; end
        if (!mfound && !ffound) begin slot = m_rr; m_rr = (m_rr + 1) % N; end
        m_v[slot] = 1'b1; m_pc[slot] = upc; m_tg[slot] = utg;
      end
      if (psh && pp && m_rc > 0) begin
        m_ras[m_rp] = pa;
      end else if (psh) begin
        m_rp = (m_rp + 1) % D; m_ras[m_rp] = pa;
        if (m_rc < D) m_rc++;
      end else if (pp && m_rc > 0) begin
        m_rp = (m_rp + D - 1) % D; m_rc--;
      end
    end
    if (cw) m_ctrl = {cd[5:2], 1'b0, cd[0]};
  endtask

  task automatic wr_ctrl(input bit [5:0] cd, input string tag);
    step(1, cd, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, tag);
  endtask
  task automatic alloc(input logic [31:0] pc, input logic [31:0] tg, input bit tk, input string tag);
    step(0, 0, 0, 0, 0, 1, pc, tg, tk, 0, 0, 0, tag);
  endtask
  task automatic look(input logic [31:0] pc, input string tag);
    step(0, 0, 1, pc, 0, 0, 0, 0, 0, 0, 0, 0, tag);
  endtask
  task automatic ret_look(input bit pp, input string tag);
    step(0, 0, 1, 0, 1, 0, 0, 0, 0, 0, 0, pp, tag);
  endtask
  task automatic push(input logic [31:0] a, input string tag);
    step(0, 0, 0, 0, 0, 0, 0, 0, 0, 1, a, 0, tag);
  endtask

  initial begin
    int seed;
    m_ctrl = '0;
    model_reset();
    seed = $urandom(32'd20240611);
    repeat (3) @(posedge clk);
    rst_n = 1'b1;

    // R1: reset state, nothing predicted
    look(32'h100, "R1");
    // R4: disabled, a taken update must not allocate
    alloc(32'h100, 32'h180, 1, "R4");
    wr_ctrl(6'h01, "R4");
    look(32'h100, "R4");
    // R2: allocate and hit
    alloc(32'h100, 32'h180, 1, "R2");
    look(32'h100, "R2");
    // R3: flush with lookup in the same cycle misses, then stays empty
    step(1, 6'h03, 1, 32'h100, 0, 0, 0, 0, 0, 0, 0, 0, "R3");
    look(32'h100, "R3");
    // R5/R7: forward-only allocation; equal target counts as forward
    wr_ctrl(6'h09, "R5");
    alloc(32'h200, 32'h1F0, 1, "R5");
    look(32'h200, "R5");
    alloc(32'h300, 32'h300, 1, "R7");
    look(32'h300, "R7");
    // R6: backward-only prediction
    wr_ctrl(6'h11, "R6");
    look(32'h300, "R6");
    alloc(32'h200, 32'h1F0, 1, "R6");
    look(32'h200, "R6");
    // R8: overwrite in place
    wr_ctrl(6'h01, "R8");
    alloc(32'h300, 32'h340, 1, "R8");
    look(32'h300, "R8");
    // R10: not-taken update ignored
    alloc(32'h400, 32'h480, 0, "R10");
    look(32'h400, "R10");
    // R9: fill then round-robin eviction
    wr_ctrl(6'h03, "R9");
    for (int i = 0; i < N + 2; i++) alloc(32'h1000 + i * 32, 32'h2000 + i, 1, "R9");
    for (int i = 0; i < N + 2; i++) look(32'h1000 + i * 32, "R9");
    // R11/R12: wrap then drain the return stack
    for (int i = 0; i < D + 1; i++) push(32'h8000 + i * 4, "R12");
    for (int i = 0; i < D + 1; i++) ret_look(1, "R11");
    ret_look(0, "R12");
    step(0, 0, 1, 0, 1, 0, 0, 0, 0, 1, 32'h9000, 1, "R11");
    push(32'h9100, "R11");
    step(0, 0, 1, 0, 1, 0, 0, 0, 0, 1, 32'h9200, 1, "R11");
    ret_look(0, "R11");
    // R3: flush clears the return stack
    wr_ctrl(6'h03, "R3");
    ret_look(0, "R3");

    // Constrained random traffic over a small address pool
    for (int k = 0; k < 4000; k++) begin
      bit cw, lr, ps, pp, uv, tk;
      bit [5:0] cd;
      logic [31:0] lp, up, ut;
      cw = ($urandom % 60) == 0;
      cd = {2'($urandom % 4), 2'($urandom % 4), ($urandom % 5) == 0, ($urandom % 8) != 0};
      if (($urandom % 3) == 0) cd[5:2] = 4'b0000;
      lp = 32'h4000 + ($urandom % 12) * 16;
      up = 32'h4000 + ($urandom % 12) * 16;
      ut = 32'h4000 + ($urandom % 12) * 16;
      lr = ($urandom % 8) == 0;
      uv = ($urandom % 2) == 0;
      tk = ($urandom % 4) != 0;
      ps = ($urandom % 8) == 0;
      pp = ($urandom % 8) == 0;
      step(cw, cd, 1, lp, lr, uv, up, ut, tk, ps, 32'h7000 + $urandom % 256, pp, "R2/R5/R6/R9/R11");
    end

    done = 1'b1;
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      miscompares++;
      $display("FAIL watchdog expired");
      $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

endmodule